// File: doc/BRIEF.md
# Serial-Fed Binary 3x3 Window Builder

This block takes a grayscale picture that arrives one byte per pixel on a serial peripheral (SPI) slave link and turns it into a stream of 3x3 binary neighbourhoods for a first binary convolution layer. The serial clock is slower than the system clock. All three serial lines are synchronised into the system domain and the serial clock's rising edge is detected there. Each assembled byte is compared against a fixed threshold, so only one bit per pixel is kept.

The kept bits pass through two one-bit-wide line stores and a three-column shift stage. Every pixel that completes a full 3x3 neighbourhood inside the picture produces one window. Border positions produce no window. Markers flag the first and last window of each picture. The position counters wrap on their own after the last pixel, so pictures can follow one another with no extra control.

Top module: `bitwin_spi_top`

## Requirements
- R1: While reset is held, and after its release until pixel data arrives, `win_valid`, `frame_first`, `frame_last` and `win_bits` are all 0.
- R2: Serial mode 0. `spi_mosi` is sampled on each rising edge of `spi_sclk` while `spi_csn` is low. The first bit received is the pixel's most significant bit. Eight bits form one pixel.
- R3: Raising `spi_csn` discards a partially received byte. The next byte starts again at its most significant bit.
- R4: A rising edge of `spi_sclk` that reaches the block in the same system cycle as the rising edge of `spi_csn` is ignored and produces no pixel.
- R5: A pixel becomes bit 1 when its value is 128 or more, and bit 0 otherwise.
- R6: Window bit `8 - (3*i + j)` holds the pixel at row `r-2+i`, column `c-2+j`, where (r, c) is the newest pixel and i, j run from 0 to 2. Bit 8 is the top-left pixel and bit 0 the bottom-right.
- R7: A window is produced only for a pixel with row >= 2 and column >= 2, in raster order. This gives 30 x 30 = 900 windows for a 32 x 32 picture.
- R8: `frame_first` is high together with the window of pixel (2,2), and `frame_last` together with the window of pixel (31,31). Neither marker is ever high without `win_valid`.
- R9: After the 1024th pixel, row and column restart at 0. The first two rows of the next picture produce no window.
- R10: `win_valid` is a single-cycle strobe, one for each qualifying pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_csn | input | 1 | Chip select, active low |
| win_bits | output | 9 | Binary 3x3 window, bit 8 top-left |
| win_valid | output | 1 | Window strobe |
| frame_first | output | 1 | First window of a picture |
| frame_last | output | 1 | Last window of a picture |

## Verification
The delicate coincidence is a serial-clock rising edge and a chip-select release arriving in the same system cycle. The edge detector then sees a valid edge while the select logic clears the bit counter. The bench provokes this by driving the eighth rising edge of a byte and the release of `spi_csn` at the same moment. Both signals pass through synchronisers of equal depth, so they land on the same system edge. The check is that no extra pixel appears: every later window must still match the model of the picture, so a single stray pixel would shift all remaining windows and be caught.

// File: rtl/bw_pkg.sv
package bw_pkg;

   // one vertical slice of the 3x3 neighbourhood
   typedef struct packed {
      logic top;
      logic mid;
      logic bot;
   } bw_col_t;

   localparam int unsigned BW_WIN_BITS = 9;

endpackage

// File: rtl/bw_spi_rx.sv
// Oversampling serial receiver: synchronises the pins, finds rising
// clock edges and assembles MSB-first words.
module bw_spi_rx #(
   parameter int PIX_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sclk,
   input  logic             mosi,
   input  logic             csn,
   output logic             cs_idle,
   output logic             byte_stb,
   output logic [PIX_W-1:0] byte_val
);

   localparam int CNT_W = (PIX_W > 2) ? $clog2(PIX_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PIX_W - 1);

   logic [SYNC_STAGES-1:0] sclk_sr;
   logic [SYNC_STAGES-1:0] mosi_sr;
   logic [SYNC_STAGES-1:0] csn_sr;
   logic                   sclk_s;
   logic                   mosi_s;
   logic                   csn_s;
   logic                   sclk_prev;
   logic                   rise;
   logic [PIX_W-1:0]       shreg;
   logic [PIX_W-1:0]       next_word;
   logic [CNT_W-1:0]       bitcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_sr <= '0;
         mosi_sr <= '0;
         csn_sr  <= '1;
      end else begin
         sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
         mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
         csn_sr  <= {csn_sr[SYNC_STAGES-2:0], csn};
      end
   end

   assign sclk_s    = sclk_sr[SYNC_STAGES-1];
   assign mosi_s    = mosi_sr[SYNC_STAGES-1];
   assign csn_s     = csn_sr[SYNC_STAGES-1];
   assign rise      = sclk_s & ~sclk_prev;
   assign next_word = {shreg[PIX_W-2:0], mosi_s};
   assign cs_idle   = csn_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_prev <= 1'b0;
         shreg     <= '0;
         bitcnt    <= '0;
         byte_stb  <= 1'b0;
         byte_val  <= '0;
      end else begin
         byte_stb  <= 1'b0;
         sclk_prev <= sclk_s;
         if (csn_s) begin
            // deselect wins over a coincident edge
            bitcnt <= '0;
         end else if (rise) begin
            shreg <= next_word;
            if (bitcnt == LAST_BIT) begin
               bitcnt   <= '0;
               byte_stb <= 1'b1;
               byte_val <= next_word;
            end else begin
               bitcnt <= bitcnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/bw_thresh.sv
// Pixel binariser; a mid-scale threshold reduces to the top bit.
module bw_thresh #(
   parameter int PIX_W  = 8,
   parameter int THRESH = 128
) (
   input  logic [PIX_W-1:0] pix,
   output logic             bit_o
);

   generate
      if (THRESH == (1 << (PIX_W - 1))) begin : g_msb
         assign bit_o = pix[PIX_W-1];
      end else begin : g_cmp
         localparam logic [PIX_W-1:0] THR = PIX_W'(THRESH);
         assign bit_o = (pix >= THR);
      end
   endgenerate

endmodule

// File: rtl/bw_linebuf.sv
// Two one-bit line stores in cascade; shift or circular variant.
module bw_linebuf #(
   parameter int DEPTH = 32,
   parameter bit CIRC  = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic din,
   output logic tap_near,
   output logic tap_far
);

   generate
      if (CIRC) begin : g_circ
         localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
         localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
         logic [PW-1:0] ptr;
         logic          mem_near [DEPTH];
         logic          mem_far  [DEPTH];

         assign tap_near = mem_near[ptr];
         assign tap_far  = mem_far[ptr];

         always_ff @(posedge clk) begin
            if (rst) begin
               ptr <= '0;
               for (int i = 0; i < DEPTH; i++) begin
                  mem_near[i] <= 1'b0;
                  mem_far[i]  <= 1'b0;
               end
            end else if (adv) begin
               mem_near[ptr] <= din;
               mem_far[ptr]  <= mem_near[ptr];
               ptr           <= (ptr == LAST) ? '0 : ptr + 1'b1;
            end
         end
      end else begin : g_shift
         logic [DEPTH-1:0] lb_near;
         logic [DEPTH-1:0] lb_far;

         assign tap_near = lb_near[DEPTH-1];
         assign tap_far  = lb_far[DEPTH-1];

         always_ff @(posedge clk) begin
            if (rst) begin
               lb_near <= '0;
               lb_far  <= '0;
            end else if (adv) begin
               lb_near <= {lb_near[DEPTH-2:0], din};
               lb_far  <= {lb_far[DEPTH-2:0], lb_near[DEPTH-1]};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bw_winbuild.sv
// Raster position tracking, window assembly and frame markers.
module bw_winbuild
   import bw_pkg::*;
#(
   parameter int IMG_W   = 32,
   parameter int IMG_H   = 32,
   parameter bit LB_CIRC = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   px_stb,
   input  logic                   px_bit,
   output logic [BW_WIN_BITS-1:0] win_bits,
   output logic                   win_valid,
   output logic                   frame_first,
   output logic                   frame_last
);

   localparam int CW = $clog2(IMG_W);
   localparam int RW = $clog2(IMG_H);
   localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
   localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
   localparam logic [CW-1:0] COL_TWO  = CW'(2);
   localparam logic [RW-1:0] ROW_TWO  = RW'(2);

   logic [CW-1:0]          col_q;
   logic [RW-1:0]          row_q;
   logic                   tap_near;
   logic                   tap_far;
   bw_col_t                cur_col;
   bw_col_t                col_a;
   bw_col_t                col_b;
   logic [BW_WIN_BITS-1:0] win_next;
   logic                   in_core;
   logic                   at_first;
   logic                   at_last;

   bw_linebuf #(
      .DEPTH (IMG_W),
      .CIRC  (LB_CIRC)
   ) u_lb (
      .clk      (clk),
      .rst      (rst),
      .adv      (px_stb),
      .din      (px_bit),
      .tap_near (tap_near),
      .tap_far  (tap_far)
   );

   assign cur_col = '{top: tap_far, mid: tap_near, bot: px_bit};

   assign win_next = {col_b.top, col_a.top, cur_col.top,
                      col_b.mid, col_a.mid, cur_col.mid,
                      col_b.bot, col_a.bot, cur_col.bot};

   assign in_core  = (row_q >= ROW_TWO) && (col_q >= COL_TWO);
   assign at_first = (row_q == ROW_TWO) && (col_q == COL_TWO);
   assign at_last  = (row_q == ROW_LAST) && (col_q == COL_LAST);

   // raster position of the incoming pixel
   always_ff @(posedge clk) begin
      if (rst) begin
         col_q <= '0;
         row_q <= '0;
      end else if (px_stb) begin
         if (col_q == COL_LAST) begin
            col_q <= '0;
            row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   // column history for the two left slices
   always_ff @(posedge clk) begin
      if (rst) begin
         col_a <= '0;
         col_b <= '0;
      end else if (px_stb) begin
         col_a <= cur_col;
         col_b <= col_a;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         win_bits    <= '0;
         win_valid   <= 1'b0;
         frame_first <= 1'b0;
         frame_last  <= 1'b0;
      end else begin
         win_valid   <= px_stb & in_core;
         frame_first <= px_stb & at_first;
         frame_last  <= px_stb & at_last;
         if (px_stb && in_core) begin
            win_bits <= win_next;
         end
      end
   end

endmodule

// File: rtl/bitwin_spi_top.sv
module bitwin_spi_top #(
   parameter int IMG_W       = 32,
   parameter int IMG_H       = 32,
   parameter int PIX_W       = 8,
   parameter int THRESH      = 128,
   parameter int SYNC_STAGES = 2,
   parameter bit LB_CIRC     = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       spi_sclk,
   input  logic       spi_mosi,
   input  logic       spi_csn,
   output logic [8:0] win_bits,
   output logic       win_valid,
   output logic       frame_first,
   output logic       frame_last
);

   generate
      if (IMG_W < 3 || IMG_H < 3) begin : g_bad_size
         $error("picture must be at least 3x3");
      end
      if (PIX_W < 2) begin : g_bad_pix
         $error("pixel width must be at least 2");
      end
      if (THRESH < 0 || THRESH >= (1 << PIX_W)) begin : g_bad_thr
         $error("threshold outside pixel range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchroniser stages required");
      end
   endgenerate

   logic             rx_cs_idle;
   logic             rx_byte_stb;
   logic [PIX_W-1:0] rx_byte;
   logic             px_bit;

   bw_spi_rx #(
      .PIX_W       (PIX_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk      (clk),
      .rst      (rst),
      .sclk     (spi_sclk),
      .mosi     (spi_mosi),
      .csn      (spi_csn),
      .cs_idle  (rx_cs_idle),
      .byte_stb (rx_byte_stb),
      .byte_val (rx_byte)
   );

   bw_thresh #(
      .PIX_W  (PIX_W),
      .THRESH (THRESH)
   ) u_thr (
      .pix   (rx_byte),
      .bit_o (px_bit)
   );

   bw_winbuild #(
      .IMG_W   (IMG_W),
      .IMG_H   (IMG_H),
      .LB_CIRC (LB_CIRC)
   ) u_win (
      .clk         (clk),
      .rst         (rst),
      .px_stb      (rx_byte_stb),
      .px_bit      (px_bit),
      .win_bits    (win_bits),
      .win_valid   (win_valid),
      .frame_first (frame_first),
      .frame_last  (frame_last)
   );

endmodule

// File: rtl/bw_chk.sv
module bw_chk #(
   parameter int IMG_W  = 32,
   parameter int IMG_H  = 32,
   parameter int PIX_W  = 8,
   parameter int THRESH = 128
) (
   input logic             clk,
   input logic             rst,
   input logic             cs_idle,
   input logic             byte_stb,
   input logic [PIX_W-1:0] byte_val,
   input logic [8:0]       win_bits,
   input logic             win_valid,
   input logic             frame_first,
   input logic             frame_last
);

   localparam logic [31:0] NWIN = 32'((IMG_W - 2) * (IMG_H - 2));
   localparam logic [PIX_W-1:0] THR = PIX_W'(THRESH);

   logic [31:0] wcnt;
   logic [31:0] wcnt_n;

   assign wcnt_n = frame_first ? 32'd1 : wcnt + 32'd1;

   always_ff @(posedge clk) begin
      if (rst) begin
         wcnt <= '0;
      end else if (win_valid) begin
         wcnt <= frame_last ? 32'd0 : wcnt_n;
      end
   end

   p_after_reset_r1: assert property (@(posedge clk)
      $fell(rst) |-> !win_valid && !frame_first && !frame_last);

   p_deselect_blocks_r4: assert property (@(posedge clk) disable iff (rst)
      byte_stb |-> !$past(cs_idle));

   p_threshold_r5: assert property (@(posedge clk) disable iff (rst)
      byte_stb |=> (!win_valid || win_bits[0] == ($past(byte_val) >= $past(THR))));

   p_count_r7: assert property (@(posedge clk) disable iff (rst)
      (win_valid && frame_last) |-> (wcnt_n == NWIN));

   p_first_valid_r8: assert property (@(posedge clk) disable iff (rst)
      frame_first |-> win_valid);

   p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
      frame_last |-> win_valid);

   p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
      win_valid |=> !win_valid);

endmodule

bind bitwin_spi_top bw_chk #(
   .IMG_W  (IMG_W),
   .IMG_H  (IMG_H),
   .PIX_W  (PIX_W),
   .THRESH (THRESH)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cs_idle     (rx_cs_idle),
   .byte_stb    (rx_byte_stb),
   .byte_val    (rx_byte),
   .win_bits    (win_bits),
   .win_valid   (win_valid),
   .frame_first (frame_first),
   .frame_last  (frame_last)
);

// File: tb/sim_bitwin_spi_top.sv
module sim_bitwin_spi_top;

   localparam int W  = 32;
   localparam int H  = 32;
   localparam int NW = (W - 2) * (H - 2);

   // {pixel value, expected bit}
   localparam logic [8:0] TV [8] = '{
      {8'd0,   1'b0}, {8'd127, 1'b0}, {8'd128, 1'b1}, {8'd129, 1'b1},
      {8'd255, 1'b1}, {8'd1,   1'b0}, {8'd64,  1'b0}, {8'd200, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sclk = 1'b0;
   logic       mosi = 1'b0;
   logic       csn = 1'b1;
   logic [8:0] win_bits;
   logic       win_valid;
   logic       frame_first;
   logic       frame_last;

   int checks = 0;
   int errors = 0;
   bit expb [2][H][W];
   int win_idx = 0;
   int frame_no = 0;
   int wins_seen [3] = '{0, 0, 0};
   logic prev_valid = 1'b0;

   always #4 clk = ~clk;

   bitwin_spi_top u0 (
      .clk         (clk),
      .rst         (rst),
      .spi_sclk    (sclk),
      .spi_mosi    (mosi),
      .spi_csn     (csn),
      .win_bits    (win_bits),
      .win_valid   (win_valid),
      .frame_first (frame_first),
      .frame_last  (frame_last)
   );

   task automatic check(input bit ok, input string msg, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic half();
      repeat (2) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         mosi = v[7-i];
         half();
         sclk = 1'b1;
         half();
         sclk = 1'b0;
      end
   endtask

   task automatic cs_on();
      csn = 1'b0;
      half();
   endtask

   task automatic cs_off();
      csn = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // R4: eighth rising edge and deselect reach the pins together
   task automatic collide();
      send_bits(8'hFF, 7);
      mosi = 1'b1;
      half();
      sclk = 1'b1;
      csn  = 1'b1;
      half();
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      cs_on();
   endtask

   function automatic int pix1(input int r, input int c);
      return ((r * 37) ^ (c * 11) ^ (r * c)) & 255;
   endfunction

   // window monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (win_valid) begin
            int r;
            int c;
            logic [8:0] e;
            if (frame_no > 1) begin
               check(1'b0, "R9 window from first rows of next picture", 1, 0);
            end else begin
               r = 2 + win_idx / (W - 2);
               c = 2 + win_idx % (W - 2);
               for (int i = 0; i < 3; i++)
                  for (int j = 0; j < 3; j++)
                     e[8-(3*i+j)] = expb[frame_no][r-2+i][c-2+j];
               check(win_bits == e,
                     (frame_no == 0) ? "R2/R5/R6 window from threshold table"
                                     : "R6/R7 window of second picture",
                     int'(win_bits), int'(e));
               check(frame_first == (win_idx == 0), "R8 frame_first",
                     int'(frame_first), int'(win_idx == 0));
               check(frame_last == (win_idx == NW - 1), "R8 frame_last",
                     int'(frame_last), int'(win_idx == NW - 1));
            end
            check(!prev_valid, "R10 strobe longer than one cycle", 1, 0);
            wins_seen[(frame_no > 2) ? 2 : frame_no]++;
            win_idx++;
            if (win_idx == NW) begin
               win_idx = 0;
               frame_no++;
            end
         end else if (frame_first || frame_last) begin
            check(1'b0, "R8 marker without window", 1, 0);
         end
         prev_valid = win_valid;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
   end

   initial begin
      // R1 during and after reset
      repeat (5) @(negedge clk);
      check({win_valid, frame_first, frame_last, win_bits} == 12'd0,
            "R1 outputs in reset", int'({win_valid, frame_first, frame_last, win_bits}), 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      check({win_valid, frame_first, frame_last, win_bits} == 12'd0,
            "R1 outputs after reset", int'({win_valid, frame_first, frame_last, win_bits}), 0);

      // R3: a partial byte discarded by deselect
      cs_on();
      send_bits(8'hFF, 3);
      cs_off();

      // first picture walks the threshold table, one select per row
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++)
            expb[0][r][c] = TV[(r * W + c + r) % 8][0];
      for (int r = 0; r < H; r++) begin
         cs_on();
         for (int c = 0; c < W; c++)
            send_bits(TV[(r * W + c + r) % 8][8:1], 8);
         cs_off();
      end

      // second picture under one select, with R4 collision and R3 partial
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++)
            expb[1][r][c] = (pix1(r, c) >= 128);
      cs_on();
      for (int r = 0; r < H; r++) begin
         for (int c = 0; c < W; c++) begin
            if (r == 10 && c == 5) collide();
            if (r == 20 && c == 0) begin
               send_bits(8'h00, 5);
               cs_off();
               cs_on();
            end
            send_bits(8'(pix1(r, c)), 8);
         end
      end
      cs_off();
      repeat (20) @(negedge clk);

      check(wins_seen[0] == NW, "R7 window count first picture", wins_seen[0], NW);
      check(wins_seen[1] == NW, "R4 R7 R9 window count second picture", wins_seen[1], NW);
      check(frame_no == 2, "R9 pictures completed", frame_no, 2);

      // R9: first two rows of a third picture give no window
      cs_on();
      for (int k = 0; k < 2 * W; k++) send_bits(8'hFF, 8);
      cs_off();
      repeat (20) @(negedge clk);
      check(wins_seen[2] == 0, "R9 no window in rows 0 and 1", wins_seen[2], 0);
      check(!win_valid && !frame_first && !frame_last, "R9 idle after rows 0 and 1",
            int'({win_valid, frame_first, frame_last}), 0);

      summary();
   end

endmodule